// File: doc/BRIEF.md
# Half-Precision Float Class Tester

This block classifies one IEEE 754 binary16 value into a fixed set of special categories and reduces the result to a single flag. The categories are quiet NaN, signalling NaN, positive zero, negative zero, positive infinity, negative infinity, denormal and finite negative. An 8-bit category-select byte picks which categories count. A category hit counts only when its select bit is set, and all the counted hits are ORed into one boolean.

That boolean lands in bit 0 of a wide mask word. Every other bit of the word is zero. An optional writemask can force bit 0 to zero: when the writemask is enabled and the writemask bit is clear, bit 0 is zero.

In the default registered variant, a valid input produces its result one clock later, marked by the output-valid signal. The block raises no exceptions and has no status outputs.

Top module: `fp16_class_tester`

## Requirements
- R1: Select bit 0 (quiet NaN) hits when exponent bits 14:10 are all ones, mantissa bits 9:0 are nonzero and mantissa bit 9 is set, for either sign.
- R2: Select bit 7 (signalling NaN) hits when exponent bits 14:10 are all ones, mantissa bit 9 is clear and mantissa bits 8:0 are nonzero, for either sign.
- R3: Select bit 1 hits only for 16'h0000 (+0), and select bit 2 hits only for 16'h8000 (-0).
- R4: Select bit 3 hits only for 16'h7C00 (+infinity), and select bit 4 hits only for 16'hFC00 (-infinity).
- R5: Select bit 5 (denormal) hits when exponent bits 14:10 are zero and the mantissa is nonzero, for either sign.
- R6: Select bit 6 (finite negative) hits when sign bit 15 is set and the value is neither NaN nor infinity; this includes -0 and negative denormals.
- R7: Result bit 0 is the OR of all selected category hits; with a select byte of zero it is 0.
- R8: When writemask enable is 1 and the writemask bit is 0, result bit 0 is 0; when enable is 0, or the writemask bit is 1, bit 0 carries the classification.
- R9: Mask bits MASK_W-1 down to 1 are always 0.
- R10: In the registered variant, outValid follows inValid one clock later, and maskOut updates in that same cycle; when inValid is low, maskOut holds its previous value.
- R11: While reset is asserted, outValid and maskOut are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input operands are valid this cycle |
| srcVal | input | 16 | Binary16 value to classify |
| catSel | input | 8 | Category select byte |
| wmBit | input | 1 | Writemask bit 0 |
| wmEnable | input | 1 | 1 when a writemask applies |
| outValid | output | 1 | maskOut carries a new result |
| maskOut | output | MASK_W | Result mask; only bit 0 can be set |

## Verification
The assertions assume that every input carries a known 0 or 1 from the first clock edge after reset. They also assume that reset is held across at least one edge. With those assumptions, a comparison made one cycle after an accepted input sees exactly that input's operands.

The stimulus drives every input from time zero, changes them only on falling edges, and holds reset for several edges before the first accepted value. The bench sweeps all 65536 encodings twice: once with each category selected on its own, and once with pseudo-random select bytes and writemask settings. It also checks idle cycles for hold behaviour.

// File: rtl/fp16cls_pkg.sv
package fp16cls_pkg;
  localparam int EXP_W = 5;
  localparam int MAN_W = 10;
  localparam int VAL_W = 1 + EXP_W + MAN_W;
  localparam int SEL_W = 8;

  // Packed so that bit n lines up with select bit n.
  typedef struct packed {
    logic sigNan;   // 7
    logic finNeg;   // 6
    logic denorm;   // 5
    logic negInf;   // 4
    logic posInf;   // 3
    logic negZero;  // 2
    logic posZero;  // 1
    logic quietNan; // 0
  } catHits_t;

  typedef struct packed {
    logic load;     // capture a new result
    logic passBit;  // writemask lets the result through
  } ctrlStrobes_t;
endpackage

// File: rtl/fp16cls_decode.sv
module fp16cls_decode
  import fp16cls_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int MW = MAN_W,
  localparam int TW = 1 + EW + MW
) (
  input  logic [TW-1:0] val,
  output catHits_t      hits
);
  logic          signBit;
  logic [EW-1:0] expField;
  logic [MW-1:0] manField;
  logic          expOnes;
  logic          expZero;
  logic          manZero;
  logic          isNan;
  logic          isInf;

  assign signBit  = val[TW-1];
  assign expField = val[TW-2:MW];
  assign manField = val[MW-1:0];
  assign expOnes  = &expField;
  assign expZero  = ~|expField;
  assign manZero  = ~|manField;
  assign isNan    = expOnes & ~manZero;
  assign isInf    = expOnes & manZero;

  always_comb begin
    hits          = '0;
    hits.quietNan = isNan & manField[MW-1];
    hits.sigNan   = isNan & ~manField[MW-1];
    hits.posZero  = expZero & manZero & ~signBit;
    hits.negZero  = expZero & manZero & signBit;
    hits.posInf   = isInf & ~signBit;
    hits.negInf   = isInf & signBit;
    hits.denorm   = expZero & ~manZero;
    hits.finNeg   = signBit & ~expOnes;
  end
endmodule

// File: rtl/fp16cls_ctrl.sv
module fp16cls_ctrl
  import fp16cls_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         wmBit,
  input  logic         wmEnable,
  output ctrlStrobes_t strobes,
  output logic         outValid
);
  always_comb begin
    strobes.load    = inValid;
    strobes.passBit = ~wmEnable | wmBit;
  end

  generate
    if (REGISTERED) begin : g_reg
      logic validQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) validQ <= 1'b0;
        else       validQ <= inValid;
      end
      assign outValid = validQ;
    end else begin : g_comb
      assign outValid = inValid;
    end
  endgenerate
endmodule

// File: rtl/fp16cls_datapath.sv
module fp16cls_datapath
  import fp16cls_pkg::*;
#(
  parameter int MASK_W     = 64,
  parameter bit REGISTERED = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [VAL_W-1:0]   srcVal,
  input  logic [SEL_W-1:0]   catSel,
  input  ctrlStrobes_t       strobes,
  output logic [MASK_W-1:0]  maskOut
);
  catHits_t    hits;
  logic        anyHit;
  logic        resBit;

  fp16cls_decode #(.EW(EXP_W), .MW(MAN_W)) decode_i (
    .val  (srcVal),
    .hits (hits)
  );

  assign anyHit = |(hits & catSel);
  assign resBit = anyHit & strobes.passBit;

  generate
    if (REGISTERED) begin : g_reg
      logic resQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             resQ <= 1'b0;
        else if (strobes.load) resQ <= resBit;
      end
      assign maskOut = {{(MASK_W-1){1'b0}}, resQ};
    end else begin : g_comb
      assign maskOut = {{(MASK_W-1){1'b0}}, resBit};
    end
  endgenerate
endmodule

// File: rtl/fp16_class_tester.sv
module fp16_class_tester
  import fp16cls_pkg::*;
#(
  parameter int MASK_W     = 64,
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [15:0]       srcVal,
  input  logic [7:0]        catSel,
  input  logic              wmBit,
  input  logic              wmEnable,
  output logic              outValid,
  output logic [MASK_W-1:0] maskOut
);
  ctrlStrobes_t strobes;

  fp16cls_ctrl #(.REGISTERED(REGISTERED)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .wmBit    (wmBit),
    .wmEnable (wmEnable),
    .strobes  (strobes),
    .outValid (outValid)
  );

  fp16cls_datapath #(.MASK_W(MASK_W), .REGISTERED(REGISTERED)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .srcVal  (srcVal),
    .catSel  (catSel),
    .strobes (strobes),
    .maskOut (maskOut)
  );
endmodule

// File: rtl/fp16cls_chk.sv
module fp16cls_chk #(
  parameter int MASK_W     = 64,
  parameter bit REGISTERED = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [15:0]       srcVal,
  input logic [7:0]        catSel,
  input logic              wmBit,
  input logic              wmEnable,
  input logic              outValid,
  input logic [MASK_W-1:0] maskOut
);
  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    maskOut[MASK_W-1:1] == '0);

  generate
    if (REGISTERED) begin : g_reg
      // R10
      valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> outValid);
      // R10
      valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> !outValid);
      // R10
      hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> $stable(maskOut));
      // R8
      wm_block_chk: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && wmEnable && !wmBit) |=> !maskOut[0]);
      // R7
      no_select_chk: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && catSel == 8'h00) |=> !maskOut[0]);
      // R4
      pos_inf_chk: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && srcVal == 16'h7C00 && catSel[3] && (!wmEnable || wmBit))
          |=> maskOut[0]);
    end
  endgenerate
endmodule

bind fp16_class_tester fp16cls_chk #(.MASK_W(MASK_W), .REGISTERED(REGISTERED)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .srcVal   (srcVal),
  .catSel   (catSel),
  .wmBit    (wmBit),
  .wmEnable (wmEnable),
  .outValid (outValid),
  .maskOut  (maskOut)
);

// File: tb/fp16_class_tester_tb_top.sv
`timescale 1ns/1ps
module fp16_class_tester_tb_top;
  localparam int MW = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [15:0]   srcVal = '0;
  logic [7:0]    catSel = '0;
  logic          wmBit = 1'b0;
  logic          wmEnable = 1'b0;
  logic          outValid;
  logic [MW-1:0] maskOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit expBit = 0;
  bit expQ[$];
  bit vldQ[$];
  string tagQ[$];
  int unsigned lfsr = 32'h1ACE_B00C;

  always #4 clk = ~clk;

  fp16_class_tester #(.MASK_W(MW), .REGISTERED(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcVal(srcVal),
    .catSel(catSel), .wmBit(wmBit), .wmEnable(wmEnable),
    .outValid(outValid), .maskOut(maskOut));

  // Behavioural reference: which select index does this value hit?
  function automatic bit refHit(input int v, input int sel);
    int s = v / 32768;
    int e = (v / 1024) % 32;
    int m = v % 1024;
    bit r = 0;
    if (e == 31 && m != 0 && m >= 512 && sel % 2 == 1) r = 1;      // R1
    if (e == 31 && m != 0 && m < 512 && (sel / 128) % 2 == 1) r = 1; // R2
    if (v == 0 && (sel / 2) % 2 == 1) r = 1;                        // R3
    if (v == 32768 && (sel / 4) % 2 == 1) r = 1;                    // R3
    if (v == 31744 && (sel / 8) % 2 == 1) r = 1;                    // R4
    if (v == 64512 && (sel / 16) % 2 == 1) r = 1;                   // R4
    if (e == 0 && m != 0 && (sel / 32) % 2 == 1) r = 1;             // R5
    if (s == 1 && e != 31 && (sel / 64) % 2 == 1) r = 1;            // R6
    return r;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // One cycle: drive at falling edge, sample at the next falling edge.
  task automatic step(input bit vld, input int src, input int sel,
                      input bit wmE, input bit wmB, input string tag);
    inValid  = vld;
    srcVal   = src[15:0];
    catSel   = sel[7:0];
    wmEnable = wmE;
    wmBit    = wmB;
    if (vld) expBit = refHit(src, sel) && (!wmE || wmB);
    expQ.push_back(expBit);
    vldQ.push_back(vld);
    tagQ.push_back(tag);
    @(negedge clk);
    begin
      bit e = expQ.pop_front();
      bit ev = vldQ.pop_front();
      string t = tagQ.pop_front();
      check("R10 outValid", outValid, ev);
      check(t, maskOut[0], e);
      check("R9 upper bits", maskOut[MW-1:1] == '0, 1);
    end
  endtask

  function automatic int nextRand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return int'(lfsr & 32'h7FFF_FFFF);
  endfunction

  initial begin
    automatic string selTag[8] = '{"R1", "R3", "R3", "R4", "R4", "R5", "R6", "R2"};
    // R11: reset holds outputs low even with valid input present
    inValid = 1'b1; srcVal = 16'h7E00; catSel = 8'hFF;
    repeat (3) @(negedge clk);
    check("R11 outValid in reset", outValid, 0);
    check("R11 maskOut in reset", maskOut, 0);
    rstN = 1'b1;
    inValid = 1'b0;
    @(negedge clk);
    check("R11 outValid after reset", outValid, 0);
    check("R11 maskOut after reset", maskOut, 0);

    // Sweep 1: every encoding, one category at a time
    for (int i = 0; i < 65536; i++) begin
      int b = i % 8;
      step(1'b1, i, 1 << b, (i / 8) % 2 == 1, 1'b1, selTag[b]);
    end

    // Directed corners
    step(1'b1, 16'h7E00, 8'h00, 1'b0, 1'b0, "R7 empty select");
    step(1'b1, 16'h7C00, 8'h08, 1'b1, 1'b0, "R8 writemask blocks");
    step(1'b1, 16'h7C00, 8'h08, 1'b0, 1'b0, "R8 writemask off");
    step(1'b1, 16'h8001, 8'h60, 1'b0, 1'b0, "R6 negative denormal");
    step(1'b0, 16'h0000, 8'hFF, 1'b0, 1'b0, "R10 hold after one");
    step(1'b0, 16'h1234, 8'h00, 1'b1, 1'b0, "R10 hold idle");
    step(1'b1, 16'h3C00, 8'hFF, 1'b0, 1'b0, "R7 positive normal");
    step(1'b0, 16'hFC00, 8'hFF, 1'b0, 1'b0, "R10 hold after zero");

    // Sweep 2: every encoding, random select and writemask, some idle
    for (int i = 0; i < 65536; i++) begin
      int r = nextRand();
      bit wmE = (r / 256) % 2 == 1;
      bit wmB = (r / 512) % 2 == 1;
      bit vld = (r / 1024) % 8 != 0;
      string t = !vld ? "R10 hold" : (wmE && !wmB) ? "R8 masked" : "R7 random select";
      step(vld, i, r % 256, wmE, wmB, t);
    end
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end
endmodule